// File: doc/BRIEF.md
# Central Module Path Allocator

This block programs the middle stage of a three-stage switch once the input modules have been paired with output modules. For every matched input-module/output-module pair it decides which central modules carry that pair's traffic, and it produces a configuration table that gives, for each central module and each input module, the output module that the central module connects it to. An entry that carries no connection has its valid bit at zero.

The block has two modes. In single-pass mode every central module receives the same configuration, taken straight from the module match. In multi-pass mode each pair receives as many central modules as it has matched ports, and the free central modules with the lowest indices are chosen first. A central module is free for pair (i, j) only when the uplink from input module i into it and the downlink from it to output module j are both idle. The block keeps one busy bit per uplink and per downlink. A slot-clear input empties them at the start of a time slot, preset masks can mark links busy at the start of a pass, and every multi-pass allocation marks the links it uses busy. Passes inside the same time slot therefore build on one another.

A controller pulses start with the match result on the inputs. The block captures the inputs and walks the pairs one per clock cycle in ascending input-module order (states SCAN). It then raises done for one cycle (state DONE) and returns to IDLE, where it waits for the next start. Transitions: IDLE to SCAN on start; SCAN to SCAN while pairs remain; SCAN to DONE after the last input module; DONE to IDLE unconditionally.

Top module: `cm_path_alloc`

## Requirements
- R1: After reset, busy_o, done_o, shortfall_o, every cfg_vld_o bit and every link busy bit are 0.
- R2: A start_i sampled in IDLE sets busy_o from the next cycle on. done_o is high for exactly one cycle, in the cycle that begins NUM_MOD clock edges after the sampling edge. In the cycle after that, busy_o and done_o are both 0.
- R3: In single-pass mode (multi_pass_i = 0), each central module r gets cfg_vld_o[r*NUM_MOD+i] = match_vld_i[i] and an output-module field equal to match_om_i[i]. Port counts and link busy bits have no effect, and the pass leaves the link busy bits as they were after the start preset.
- R4: In multi-pass mode, a matched pair i receives min(count, free central modules) entries. The count is match_cnt_i[i] and is limited to PORTS, so any larger value is treated as PORTS.
- R5: In multi-pass mode, the central modules given to a pair are the free ones with the lowest indices.
- R6: Central module r is free for pair (i, j) only if up_link_busy_o[i*NUM_CM+r] and dn_link_busy_o[j*NUM_CM+r] are both 0. At start, up_preset_i and dn_preset_i are ORed into these bits, using the same indexing.
- R7: Pairs are handled in ascending input-module order, and each allocation marks its links busy before the next pair is handled. When two input modules name the same output module, the higher-indexed one sees the downlinks taken by the lower-indexed one.
- R8: Link busy bits persist across passes until slot_clear_i is sampled in IDLE, which zeroes them. When slot_clear_i and start_i are sampled together, the clear is applied before the preset.
- R9: shortfall_o[i] is set exactly when pair i was matched in multi-pass mode and received fewer central modules than its limited count. It is 0 in single-pass mode.
- R10: Every start clears the whole table (valid bits and output-module fields to 0). An unmatched input module, or one with a count of 0, gets no valid entry.
- R11: start_i, slot_clear_i and input changes while busy_o is high have no effect on the pass in progress.
- R12: The output-module field of entry (r, i) sits at cfg_om_o[(r*NUM_MOD+i)*OMW +: OMW], with OMW = clog2(NUM_MOD), and match_om_i and match_cnt_i are packed per input module at the same stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a pass (sampled in IDLE) |
| multi_pass_i | input | 1 | 1 = multi-pass allocation, 0 = single-pass |
| slot_clear_i | input | 1 | Zero all link busy bits (sampled in IDLE) |
| match_vld_i | input | NUM_MOD | Input module i has a matched output module |
| match_om_i | input | NUM_MOD*OMW | Matched output module of each input module |
| match_cnt_i | input | NUM_MOD*CW | Matched port count of each pair, CW = clog2(PORTS+1) |
| up_preset_i | input | NUM_MOD*NUM_CM | Uplinks to mark busy at start |
| dn_preset_i | input | NUM_MOD*NUM_CM | Downlinks to mark busy at start |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| shortfall_o | output | NUM_MOD | Pair received fewer central modules than asked |
| cfg_vld_o | output | NUM_CM*NUM_MOD | Entry (r, i) valid at bit r*NUM_MOD+i |
| cfg_om_o | output | NUM_CM*NUM_MOD*OMW | Output module of entry (r, i) |
| up_link_busy_o | output | NUM_MOD*NUM_CM | Uplink busy bits, bit i*NUM_CM+r |
| dn_link_busy_o | output | NUM_MOD*NUM_CM | Downlink busy bits, bit j*NUM_CM+r |

## Verification
The bench runs a pass whose requests exceed what the free links allow, and one whose count is above the port limit. A design that mis-counted would hand out too many central modules or fail to raise the shortfall flag, and one that did not limit the count would compare against the raw value. It also runs back-to-back passes without a slot clear, and a pass in which two input modules name one output module. A design that forgot to mark links busy, or updated them one pair too late, would then reuse a taken central module. Finally, it checks that single-pass mode ignores busy links and counts, and that a second start during a pass is dropped. A design that got these wrong would leave columns of the table differing from one another, or restart with the disturbed inputs.

// File: rtl/cm_alloc_pkg.sv
package cm_alloc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } alloc_state_t;

endpackage

// File: rtl/cm_lowest_pick.sv
// Picks up to want_i of the set bits in free_i, lowest index first.
module cm_lowest_pick #(
    parameter int NUM_CM = 8,
    parameter int CW     = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CM-1:0] free_i,
    input  logic [CW-1:0]     want_i,
    output logic [NUM_CM-1:0] pick_o,
    output logic              short_o
);

    logic [CW-1:0] taken;

    always_comb begin
        taken  = '0;
        pick_o = '0;
        for (int r = 0; r < NUM_CM; r++) begin
            if (free_i[r] && (taken < want_i)) begin
                pick_o[r] = 1'b1;
                taken     = taken + CW'(1);
            end
        end
        short_o = (taken < want_i);
    end

    // R4
    pick_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(pick_o) <= int'(want_i));

    // R9
    short_all_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        short_o |-> (pick_o == free_i));

endmodule

// File: rtl/cm_link_state.sv
// Busy bits for every input-module uplink and output-module downlink.
module cm_link_state #(
    parameter int NUM_CM  = 8,
    parameter int NUM_MOD = 4,
    parameter int OW      = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      clr_i,
    input  logic                      preset_en_i,
    input  logic [NUM_MOD*NUM_CM-1:0] up_set_i,
    input  logic [NUM_MOD*NUM_CM-1:0] dn_set_i,
    input  logic                      upd_en_i,
    input  logic [OW-1:0]             upd_im_i,
    input  logic [OW-1:0]             upd_om_i,
    input  logic [NUM_CM-1:0]         upd_mask_i,
    output logic [NUM_MOD*NUM_CM-1:0] up_busy_o,
    output logic [NUM_MOD*NUM_CM-1:0] dn_busy_o
);

    logic [NUM_MOD*NUM_CM-1:0] up_q, dn_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (preset_en_i) begin
            up_q <= (clr_i ? '0 : up_q) | up_set_i;
            dn_q <= (clr_i ? '0 : dn_q) | dn_set_i;
        end else if (clr_i) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (upd_en_i) begin
            up_q[upd_im_i*NUM_CM +: NUM_CM] <= up_q[upd_im_i*NUM_CM +: NUM_CM] | upd_mask_i;
            dn_q[upd_om_i*NUM_CM +: NUM_CM] <= dn_q[upd_om_i*NUM_CM +: NUM_CM] | upd_mask_i;
        end
    end

    assign up_busy_o = up_q;
    assign dn_busy_o = dn_q;

    // R8
    up_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((up_q & $past(up_q)) == $past(up_q)));

    // R8
    dn_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((dn_q & $past(dn_q)) == $past(dn_q)));

endmodule

// File: rtl/cm_cfg_table.sv
// Per central module, per input module: valid bit and output module.
module cm_cfg_table #(
    parameter int NUM_CM  = 8,
    parameter int NUM_MOD = 4,
    parameter int OW      = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic                         wr_en_i,
    input  logic [OW-1:0]                wr_im_i,
    input  logic [NUM_CM-1:0]            wr_mask_i,
    input  logic [OW-1:0]                wr_om_i,
    output logic [NUM_CM*NUM_MOD-1:0]    vld_o,
    output logic [NUM_CM*NUM_MOD*OW-1:0] om_o
);

    for (genvar r = 0; r < NUM_CM; r++) begin : g_col
        logic [NUM_MOD-1:0]    col_vld_q;
        logic [NUM_MOD*OW-1:0] col_om_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                col_vld_q <= '0;
                col_om_q  <= '0;
            end else if (clr_i) begin
                col_vld_q <= '0;
                col_om_q  <= '0;
            end else if (wr_en_i && wr_mask_i[r]) begin
                col_vld_q[wr_im_i]            <= 1'b1;
                col_om_q[wr_im_i*OW +: OW]    <= wr_om_i;
            end
        end

        assign vld_o[r*NUM_MOD +: NUM_MOD]      = col_vld_q;
        assign om_o[r*NUM_MOD*OW +: NUM_MOD*OW] = col_om_q;
    end

endmodule

// File: rtl/cm_path_alloc.sv
module cm_path_alloc
    import cm_alloc_pkg::*;
#(
    parameter int NUM_CM  = 8,
    parameter int NUM_MOD = 4,
    parameter int PORTS   = NUM_CM
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic                                    start_i,
    input  logic                                    multi_pass_i,
    input  logic                                    slot_clear_i,
    input  logic [NUM_MOD-1:0]                      match_vld_i,
    input  logic [NUM_MOD*((NUM_MOD > 1) ? $clog2(NUM_MOD) : 1)-1:0] match_om_i,
    input  logic [NUM_MOD*$clog2(PORTS+1)-1:0]      match_cnt_i,
    input  logic [NUM_MOD*NUM_CM-1:0]               up_preset_i,
    input  logic [NUM_MOD*NUM_CM-1:0]               dn_preset_i,
    output logic                                    busy_o,
    output logic                                    done_o,
    output logic [NUM_MOD-1:0]                      shortfall_o,
    output logic [NUM_CM*NUM_MOD-1:0]               cfg_vld_o,
    output logic [NUM_CM*NUM_MOD*((NUM_MOD > 1) ? $clog2(NUM_MOD) : 1)-1:0] cfg_om_o,
    output logic [NUM_MOD*NUM_CM-1:0]               up_link_busy_o,
    output logic [NUM_MOD*NUM_CM-1:0]               dn_link_busy_o
);

    localparam int OW = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;
    localparam int CW = $clog2(PORTS + 1);
    localparam logic [OW-1:0] LAST_IM = OW'(NUM_MOD - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(PORTS);

    alloc_state_t state_q, state_d;

    logic                   mode_q;
    logic [NUM_MOD-1:0]     vld_q;
    logic [NUM_MOD*OW-1:0]  om_q;
    logic [NUM_MOD*CW-1:0]  cnt_q;
    logic [OW-1:0]          idx_q;
    logic [NUM_MOD-1:0]     short_q;

    logic                   start_acc, clear_acc, scan_en, pair_live;
    logic [OW-1:0]          cur_om;
    logic [CW-1:0]          cur_cnt, want;
    logic [NUM_CM-1:0]      up_cur, dn_cur, free_mask, pick, wr_mask;
    logic                   pick_short;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)          state_d = ST_SCAN;
            ST_SCAN: if (idx_q == LAST_IM) state_d = ST_DONE;
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes decoded from the state
    always_comb begin
        busy_o    = 1'b0;
        done_o    = 1'b0;
        start_acc = 1'b0;
        clear_acc = 1'b0;
        scan_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_acc = start_i;
                clear_acc = slot_clear_i;
            end
            ST_SCAN: begin
                busy_o  = 1'b1;
                scan_en = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // Captured match and pair index
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q  <= 1'b0;
            vld_q   <= '0;
            om_q    <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            short_q <= '0;
        end else if (start_acc) begin
            mode_q  <= multi_pass_i;
            vld_q   <= match_vld_i;
            om_q    <= match_om_i;
            cnt_q   <= match_cnt_i;
            idx_q   <= '0;
            short_q <= '0;
        end else if (scan_en) begin
            if (pair_live && mode_q) short_q[idx_q] <= pick_short;
            if (idx_q != LAST_IM) idx_q <= idx_q + OW'(1);
        end
    end

    assign pair_live = scan_en && vld_q[idx_q];
    assign cur_om    = om_q[idx_q*OW +: OW];
    assign cur_cnt   = cnt_q[idx_q*CW +: CW];
    assign want      = (cur_cnt > CNT_MAX) ? CNT_MAX : cur_cnt;
    assign up_cur    = up_link_busy_o[idx_q*NUM_CM +: NUM_CM];
    assign dn_cur    = dn_link_busy_o[cur_om*NUM_CM +: NUM_CM];
    assign free_mask = ~up_cur & ~dn_cur;
    assign wr_mask   = mode_q ? pick : '1;

    cm_lowest_pick #(
        .NUM_CM (NUM_CM),
        .CW     (CW)
    ) u_pick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .free_i  (free_mask),
        .want_i  (want),
        .pick_o  (pick),
        .short_o (pick_short)
    );

    cm_link_state #(
        .NUM_CM  (NUM_CM),
        .NUM_MOD (NUM_MOD),
        .OW      (OW)
    ) u_links (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (clear_acc),
        .preset_en_i (start_acc),
        .up_set_i    (up_preset_i),
        .dn_set_i    (dn_preset_i),
        .upd_en_i    (pair_live && mode_q),
        .upd_im_i    (idx_q),
        .upd_om_i    (cur_om),
        .upd_mask_i  (pick),
        .up_busy_o   (up_link_busy_o),
        .dn_busy_o   (dn_link_busy_o)
    );

    cm_cfg_table #(
        .NUM_CM  (NUM_CM),
        .NUM_MOD (NUM_MOD),
        .OW      (OW)
    ) u_table (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (start_acc),
        .wr_en_i   (pair_live),
        .wr_im_i   (idx_q),
        .wr_mask_i (wr_mask),
        .wr_om_i   (cur_om),
        .vld_o     (cfg_vld_o),
        .om_o      (cfg_om_o)
    );

    assign shortfall_o = short_q;

    // Checker helper: are all table columns equal to column 0?
    logic cols_same;
    always_comb begin
        cols_same = 1'b1;
        for (int r = 1; r < NUM_CM; r++) begin
            if (cfg_vld_o[r*NUM_MOD +: NUM_MOD] != cfg_vld_o[0 +: NUM_MOD] ||
                cfg_om_o[r*NUM_MOD*OW +: NUM_MOD*OW] != cfg_om_o[0 +: NUM_MOD*OW])
                cols_same = 1'b0;
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6
    alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_live && mode_q) |-> ((pick & (up_cur | dn_cur)) == '0));

    // R3
    single_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !mode_q) |-> cols_same);

    // R9
    short_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|shortfall_o) |-> mode_q);

    // R11
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(mode_q) && $stable(vld_q) && $stable(cnt_q)));

endmodule

// File: tb/cm_path_alloc_bench.sv
`timescale 1ns/1ps
module cm_path_alloc_bench;

    localparam int M  = 8;
    localparam int K  = 4;
    localparam int N  = 8;
    localparam int OW = 2;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, multi = 1'b0, sclr = 1'b0;
    logic [K-1:0]    m_vld = '0;
    logic [K*OW-1:0] m_om  = '0;
    logic [K*CW-1:0] m_cnt = '0;
    logic [K*M-1:0]  up_pre = '0, dn_pre = '0;
    logic busy, done;
    logic [K-1:0]      shortfall;
    logic [M*K-1:0]    cfg_vld;
    logic [M*K*OW-1:0] cfg_om;
    logic [K*M-1:0]    up_busy, dn_busy;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench-side model state
    logic [M-1:0] mup [K];
    logic [M-1:0] mdn [K];
    logic [M*K-1:0]    ev;
    logic [M*K*OW-1:0] eo;
    logic [K-1:0]      es;

    always #5 clk = ~clk;

    cm_path_alloc #(.NUM_CM(M), .NUM_MOD(K), .PORTS(N)) u_cm_path_alloc (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .multi_pass_i(multi),
        .slot_clear_i(sclr), .match_vld_i(m_vld), .match_om_i(m_om),
        .match_cnt_i(m_cnt), .up_preset_i(up_pre), .dn_preset_i(dn_pre),
        .busy_o(busy), .done_o(done), .shortfall_o(shortfall),
        .cfg_vld_o(cfg_vld), .cfg_om_o(cfg_om),
        .up_link_busy_o(up_busy), .dn_link_busy_o(dn_busy)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [K*M-1:0] pack_up();
        logic [K*M-1:0] v;
        for (int i = 0; i < K; i++) v[i*M +: M] = mup[i];
        return v;
    endfunction

    function automatic logic [K*M-1:0] pack_dn();
        logic [K*M-1:0] v;
        for (int j = 0; j < K; j++) v[j*M +: M] = mdn[j];
        return v;
    endfunction

    // Expected results from the requirements
    task automatic model(input logic md, input logic clr, input logic [K-1:0] v,
                         input logic [K*OW-1:0] om, input logic [K*CW-1:0] cnt,
                         input logic [K*M-1:0] pu, input logic [K*M-1:0] pd);
        ev = '0; eo = '0; es = '0;
        for (int i = 0; i < K; i++) begin
            if (clr) begin mup[i] = '0; mdn[i] = '0; end
            mup[i] |= pu[i*M +: M];
            mdn[i] |= pd[i*M +: M];
        end
        for (int i = 0; i < K; i++) begin
            int j, want, taken;
            if (!v[i]) continue;
            j = int'(om[i*OW +: OW]);
            want = int'(cnt[i*CW +: CW]);
            if (want > N) want = N;
            taken = 0;
            for (int r = 0; r < M; r++) begin
                if (!md || (!mup[i][r] && !mdn[j][r] && taken < want)) begin
                    ev[r*K+i] = 1'b1;
                    eo[(r*K+i)*OW +: OW] = OW'(j);
                    if (md) begin
                        taken++;
                        mup[i][r] = 1'b1;
                        mdn[j][r] = 1'b1;
                    end
                end
            end
            if (md && taken < want) es[i] = 1'b1;
        end
    endtask

    task automatic run_pass(input string req, input logic md, input logic clr,
                            input logic [K-1:0] v, input logic [K*OW-1:0] om,
                            input logic [K*CW-1:0] cnt, input logic [K*M-1:0] pu,
                            input logic [K*M-1:0] pd, input bit poke);
        int cyc;
        model(md, clr, v, om, cnt, pu, pd);
        @(negedge clk);
        multi = md; sclr = clr; m_vld = v; m_om = om; m_cnt = cnt;
        up_pre = pu; dn_pre = pd; start = 1'b1;
        @(negedge clk);
        start = 1'b0; sclr = 1'b0; cyc = 1;
        while (!done && cyc < 40) begin
            if (poke && cyc == 2) begin
                // R11: disturb everything mid-pass
                start = 1'b1; sclr = 1'b1; m_vld = ~v; multi = ~md; m_cnt = '1;
            end
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b0; sclr = 1'b0; m_vld = v; multi = md; m_cnt = cnt;
            end
        end
        check("R2", {req, " done timing"}, 128'(cyc), 128'(K + 1));
        check(req, "cfg valid", 128'(cfg_vld), 128'(ev));
        check("R12", {req, " cfg om"}, 128'(cfg_om), 128'(eo));
        check("R9", {req, " shortfall"}, 128'(shortfall), 128'(es));
        check("R8", {req, " uplinks"}, 128'(up_busy), 128'(pack_up()));
        check("R8", {req, " downlinks"}, 128'(dn_busy), 128'(pack_dn()));
        @(negedge clk);
        check("R2", {req, " idle after done"}, 128'({busy, done}), 128'(0));
        up_pre = '0; dn_pre = '0;
    endtask

    task automatic t_reset();
        check("R1", "busy/done", 128'({busy, done}), 128'(0));
        check("R1", "cfg valid", 128'(cfg_vld), 128'(0));
        check("R1", "shortfall", 128'(shortfall), 128'(0));
        check("R1", "links", 128'({up_busy, dn_busy}), 128'(0));
    endtask

    task automatic t_single();
        // R3: busy preset and counts must not change the uniform table
        run_pass("R3", 1'b0, 1'b1, 4'b1011, {2'd1, 2'd3, 2'd0, 2'd2},
                 {4'd0, 4'd8, 4'd2, 4'd0}, 32'h0000_00F0, 32'h00FF_0000, 1'b0);
    endtask

    task automatic t_multi_basic();
        // R4 R5 R10: counts 2,3,1,0, nothing busy
        run_pass("R4", 1'b1, 1'b1, 4'b1111, {2'd0, 2'd1, 2'd2, 2'd3},
                 {4'd0, 4'd1, 4'd3, 4'd2}, '0, '0, 1'b0);
    endtask

    task automatic t_multi_accum();
        // R5 R8: second pass in the same slot starts above the used modules
        run_pass("R5", 1'b1, 1'b0, 4'b1111, {2'd0, 2'd1, 2'd2, 2'd3},
                 {4'd3, 4'd3, 4'd3, 4'd3}, '0, '0, 1'b0);
    endtask

    task automatic t_preset_short();
        // R6 R9 R4: IM0 uplinks 0-3 busy, OM1 downlinks 4-5 busy; IM1 count 15 limited
        run_pass("R6", 1'b1, 1'b1, 4'b0011, {2'd0, 2'd0, 2'd0, 2'd1},
                 {4'd0, 4'd0, 4'd15, 4'd8}, 32'h0000_000F, 32'h0000_3000, 1'b0);
    endtask

    task automatic t_conflict();
        // R7 R10: IM0 and IM2 both name OM2; IM1 unmatched
        run_pass("R7", 1'b1, 1'b1, 4'b0101, {2'd0, 2'd2, 2'd3, 2'd2},
                 {4'd0, 4'd5, 4'd4, 4'd5}, '0, '0, 1'b0);
    endtask

    task automatic t_start_ignored();
        run_pass("R11", 1'b1, 1'b1, 4'b1110, {2'd2, 2'd0, 2'd3, 2'd1},
                 {4'd2, 4'd4, 4'd1, 4'd6}, '0, '0, 1'b1);
    endtask

    task automatic t_slot_clear();
        @(negedge clk);
        sclr = 1'b1;
        @(negedge clk);
        sclr = 1'b0;
        for (int i = 0; i < K; i++) begin mup[i] = '0; mdn[i] = '0; end
        check("R8", "slot clear links", 128'({up_busy, dn_busy}), 128'(0));
        check("R8", "slot clear keeps table", 128'(cfg_vld), 128'(ev));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < K; i++) begin mup[i] = '0; mdn[i] = '0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi_basic();
        t_multi_accum();
        t_preset_short();
        t_conflict();
        t_start_ignored();
        t_slot_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule